// File: doc/BRIEF.md
# Cascadable Latched Serial Output Register

This block is the digital front end of a sixteen-channel sink driver. Serial data enters one bit per shift, is held in a storage latch under control of a strobe, and leaves as one on/off control bit per channel. An active-low output enable blanks all channels at once. A cascade output passes the oldest shift register bit on to the next device, so several devices can be chained into a single long register.

The block runs on a single synthesizable clock. A shift is one rising edge with the shift qualifier high. The storage latch is modelled as level sensitive: on every rising edge where the strobe is high, it takes the shift register value as it stands after that edge. This includes a shift made on the same edge. While the strobe is low, the latch keeps its value. The cascade output is retimed onto the falling edge. A downstream device that samples on the next rising edge therefore gets half a cycle of setup margin.

Top module: `led_sink_front`

## Requirements
- R1: The shift register is CHANNELS bits wide (16 by default). On a rising edge with `shift_en` high, `ser_in` enters bit 0 and every other bit moves one place toward bit CHANNELS-1.
- R2: After 16 shifts, the first bit shifted in appears on `chan_on[15]` and the last bit shifted in appears on `chan_on[0]`, once the latch has been loaded.
- R3: On a rising edge with `strobe` high, the latch takes the shift register contents including any shift made on that same edge. While `strobe` stays high, `chan_on` follows every shift.
- R4: While `strobe` is low, the latch holds its value. Shifts made during that time do not change `chan_on`.
- R5: While `oe_n` is high, `chan_on` is all zeros whatever the latch holds. When `oe_n` goes low, the held pattern reappears without being reloaded.
- R6: `ser_out` carries shift register bit CHANNELS-1. It changes only on the falling clock edge, so during the high half of the clock it still shows the bit from before that rising edge.
- R7: A synchronous active-high `rst` clears the shift register, the latch and `ser_out` to zero, so all channels are off.
- R8: On a rising edge with `shift_en` low, the shift register keeps its value.
- R9: A 1 in a latch bit turns the matching channel on, provided `oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; shifting and latching on the rising edge, cascade on the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data into bit 0 of the shift register |
| shift_en | input | 1 | Qualifies a rising edge as a shift |
| strobe | input | 1 | Level-sensitive latch control; high means the latch is transparent |
| oe_n | input | 1 | Active-low output enable; high forces all channels off |
| chan_on | output | CHANNELS | Per-channel on/off control, 1 = on |
| ser_out | output | 1 | Cascade output, bit CHANNELS-1 retimed to the falling edge |

## Verification
Two functions can meet on one rising edge: a shift and a transparent latch load. The bench drives `shift_en` and `strobe` high together on the same edge, bit after bit, across sixteen-bit patterns. It then requires that `chan_on` already shows the freshly shifted word right after that edge, and not the word from one shift earlier. A second overlap is also provoked: the cascade bit is sampled in the high half of each cycle, just after a shift has changed the top register bit. It must still show the old bit there and switch to the new bit only after the falling edge.

// File: rtl/led_front_pkg.sv
package led_front_pkg;
  parameter int unsigned DEF_CHANNELS = 16;
  localparam int unsigned MIN_CHANNELS = 2;
endpackage

// File: rtl/shift_chain.sv
module shift_chain #(
  parameter int unsigned WIDTH = led_front_pkg::DEF_CHANNELS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             ser_in,
  output logic [WIDTH-1:0] sreg_q,
  output logic [WIDTH-1:0] sreg_nx
);
  localparam int unsigned TOP = WIDTH - 1;

  always_comb begin
    sreg_nx = sreg_q;
    if (shift_en) sreg_nx = {sreg_q[TOP-1:0], ser_in};
  end

  always_ff @(posedge clk) begin
    if (rst) sreg_q <= '0;
    else     sreg_q <= sreg_nx;
  end

  // R8: idle edges leave the register untouched
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(sreg_q));

  // R1: new bit lands in bit 0, top bit taken from the old neighbour
  assert_shift_R1: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (sreg_q[0] == $past(ser_in)) && (sreg_q[TOP] == $past(sreg_q[TOP-1])));
endmodule

// File: rtl/hold_latch.sv
module hold_latch #(
  parameter int unsigned WIDTH = led_front_pkg::DEF_CHANNELS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (strobe) q <= d_in;
  end

  // R4: opaque while the strobe is low
  assert_opaque_R4: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(q));
endmodule

// File: rtl/cascade_tap.sv
module cascade_tap (
  input  logic clk,
  input  logic rst,
  input  logic msb,
  output logic ser_out
);
  always_ff @(negedge clk) begin
    if (rst) ser_out <= 1'b0;
    else     ser_out <= msb;
  end

  // R6: each falling edge shows the top bit seen at the previous falling edge
  assert_cascade_R6: assert property (@(negedge clk) disable iff (rst)
    !$past(rst) |-> ser_out == $past(msb));
endmodule

// File: rtl/led_sink_front.sv
module led_sink_front #(
  parameter int unsigned CHANNELS = led_front_pkg::DEF_CHANNELS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ser_in,
  input  logic                shift_en,
  input  logic                strobe,
  input  logic                oe_n,
  output logic [CHANNELS-1:0] chan_on,
  output logic                ser_out
);
  localparam int unsigned TOP = CHANNELS - 1;

  logic [CHANNELS-1:0] sreg_q;
  logic [CHANNELS-1:0] sreg_nx;
  logic [CHANNELS-1:0] latch_q;

  shift_chain #(.WIDTH(CHANNELS)) u_shift (
    .clk(clk), .rst(rst), .shift_en(shift_en), .ser_in(ser_in),
    .sreg_q(sreg_q), .sreg_nx(sreg_nx)
  );

  hold_latch #(.WIDTH(CHANNELS)) u_latch (
    .clk(clk), .rst(rst), .strobe(strobe), .d_in(sreg_nx), .q(latch_q)
  );

  cascade_tap u_tap (
    .clk(clk), .rst(rst), .msb(sreg_q[TOP]), .ser_out(ser_out)
  );

  // R5, R9: per-channel gate, one bit on only when enabled
  for (genvar g = 0; g < CHANNELS; g++) begin : g_gate
    assign chan_on[g] = latch_q[g] & ~oe_n;
  end

  // R3: a strobed edge leaves latch and shift register equal
  assert_transparent_R3: assert property (@(posedge clk) disable iff (rst)
    strobe |=> latch_q == sreg_q);
endmodule

// File: tb/tb_led_sink_front.sv
module tb_led_sink_front;
  localparam int CH = 16;

  logic clk = 1'b0;
  logic rst, ser_in, shift_en, strobe, oe_n;
  logic [CH-1:0] chan_on;
  logic ser_out;

  int checks = 0;
  int fails  = 0;
  logic [CH-1:0] m_sreg, m_latch;

  always #10 clk = ~clk;

  led_sink_front #(.CHANNELS(CH)) dut (
    .clk(clk), .rst(rst), .ser_in(ser_in), .shift_en(shift_en),
    .strobe(strobe), .oe_n(oe_n), .chan_on(chan_on), .ser_out(ser_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [CH-1:0] act, input logic [CH-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [CH-1:0] exp_out();
    return oe_n ? '0 : m_latch;
  endfunction

  // one rising edge with given inputs; checks outputs and both cascade phases
  task automatic tick(input logic sin, input logic sh, input logic stb, input string tag);
    logic old_msb;
    ser_in = sin; shift_en = sh; strobe = stb;
    old_msb = m_sreg[CH-1];
    @(posedge clk); #2;
    if (sh) m_sreg = {m_sreg[CH-2:0], sin};
    if (stb) m_latch = m_sreg;
    chk(chan_on === exp_out(), tag, chan_on, exp_out());
    chk(ser_out === old_msb, "R6 before fall", {15'd0, ser_out}, {15'd0, old_msb});
    @(negedge clk); #2;
    chk(ser_out === m_sreg[CH-1], "R6 after fall", {15'd0, ser_out}, {15'd0, m_sreg[CH-1]});
  endtask

  initial begin
    #4000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [CH-1:0] pat;
    rst = 1'b1; ser_in = 0; shift_en = 0; strobe = 0; oe_n = 0;
    m_sreg = '0; m_latch = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    chk(chan_on === '0, "R7 reset outputs", chan_on, '0);
    chk(ser_out === 1'b0, "R7 reset cascade", {15'd0, ser_out}, '0);
    rst = 1'b0;

    // R1 R2: load patterns with strobe low, then strobe alone
    for (int k = 0; k < 12; k++) begin
      pat = 16'(k * 16'h1357) ^ 16'(k << 9) ^ ((k % 3 == 0) ? 16'hFFFF : 16'h0000);
      for (int b = CH - 1; b >= 0; b--) tick(pat[b], 1'b1, 1'b0, "R4 hidden shift");
      tick(1'b0, 1'b0, 1'b1, "R2 strobe load");
      chk(chan_on === pat, "R2 order ch15 first", chan_on, pat);
      chk(chan_on[CH-1] === pat[CH-1] && chan_on[0] === pat[0], "R9 bit polarity", chan_on, pat);
    end

    // R3: shift and strobe on the same edges, ripple visible
    for (int b = 0; b < 2 * CH; b++)
      tick(b % 3 == 1, 1'b1, 1'b1, "R3 same-edge ripple");
    tick(1'b1, 1'b1, 1'b1, "R1 walk");

    // R8: idle edges with strobe high show an unchanged register
    pat = m_sreg;
    for (int b = 0; b < 5; b++) tick(b[0], 1'b0, 1'b1, "R8 no shift");
    chk(chan_on === pat, "R8 register held", chan_on, pat);

    // R4: hold while shifting other data
    pat = m_latch;
    for (int b = 0; b < CH; b++) tick(~b[0], 1'b1, 1'b0, "R4 hold");
    chk(chan_on === pat, "R4 latch kept", chan_on, pat);

    // R5: blanking and restoration
    oe_n = 1'b1;
    for (int b = 0; b < 4; b++) tick(1'b1, 1'b1, 1'b0, "R5 blanked");
    chk(chan_on === '0, "R5 all off", chan_on, '0);
    oe_n = 1'b0; #1;
    chk(chan_on === pat, "R5 restored", chan_on, pat);
    oe_n = 1'b1;
    tick(1'b0, 1'b1, 1'b1, "R5 load while blanked");
    oe_n = 1'b0; #1;
    chk(chan_on === m_latch, "R5 new load shown", chan_on, m_latch);

    // R7: reset mid-stream
    rst = 1'b1;
    @(posedge clk); #2;
    @(negedge clk); #2;
    m_sreg = '0; m_latch = '0;
    chk(chan_on === '0, "R7 mid reset", chan_on, '0);
    chk(ser_out === 1'b0, "R7 mid reset cascade", {15'd0, ser_out}, '0);
    rst = 1'b0;
    tick(1'b0, 1'b0, 1'b1, "R7 register cleared");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule